// File: doc/BRIEF.md
# Sleep-Mode Oscillator Power Controller

This block manages the high-speed oscillator and the gated system clock across one sleep and wake cycle. A sleep request gates the system clock at once. If a register bit allows it and the clock setup is safe, the request also removes the oscillator enable. A wake event turns the oscillator back on and starts a stabilization timer, which runs in the oscillator's own clock domain. The gated clock is released only after that wait ends, and it returns on the source selection that was in force when sleep began.

The control settings live in an option register. That register can be written only while a separate protect register holds an unlock key. The option register holds four settings:
- whether the oscillator may be stopped during sleep;
- whether timer-type interrupts may wake the chip;
- an 8-bit stabilization count;
- a scale select for that count.

The block does not switch the PLL or the clock source. The processor, the RTC and the interrupt sources are outside it and reach it only as plain signals.

Top module: `sleep_osc_ctrl`

## Requirements
- R1: Register address 1 is the protect register, and its low 8 bits are stored from any write. Writes to the option register (address 0) are accepted only while the protect register holds 0x96. Writing any other value to the protect register locks the option register again. Reading address 1 returns the stored byte in bits 7:0, with zeros above.
- R2: A write to the option register while it is locked is ignored, and the register contents do not change.
- R3: The option register has the following field layout:
  - bits 15:8: stabilization count;
  - bit 3: oscillator-off-in-sleep;
  - bit 2: wait scale;
  - bit 0: wake enable;
  - all other bits read as 0.

  After reset, both registers read 0x0000.
- R4: `sleep_req_i` pulled high while the clock runs and the timer is idle drops `clk_en_o` on the next clock edge, whatever the oscillator setting.
- R5: With bit 3 set and the configuration legal, `osc_en_o` is low for the whole sleep period. With bit 3 clear, `osc_en_o` stays high.
- R6: If bit 3 is set when sleep is entered while `pll_on_i` is 1 or `src_sel_i` is 1 (PLL selected), `cfg_err_o` is set and the oscillator keeps running through that sleep. The flag clears at the next sleep entry that is legal.
- R7: `wake_nmi_i` and `wake_dbg_i` always end sleep. `wake_rtc_i` and `wake_ext_i` end sleep only when bit 0 is 1.
- R8: After a wake event, `osc_en_o` goes high on the next edge. `clk_en_o` stays low for at least count × 8192 oscillator cycles when bit 2 is 1, or count × 128 cycles when bit 2 is 0. A count of 0 waits one unit. The clock is then released within a few cycles.
- R9: From sleep entry until clock release, `src_sel_o` holds the value `src_sel_i` had at sleep entry. While the clock runs, `src_sel_o` follows `src_sel_i`.
- R10: A wake event during the stabilization wait has no effect. A sleep request during the wait is held and taken, without a new request, shortly after the clock has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System-domain clock |
| osc_clk_i | input | 1 | High-speed oscillator clock, times the stabilization wait |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = option register, 1 = protect register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register |
| sleep_req_i | input | 1 | Sleep request from the processor |
| wake_rtc_i | input | 1 | RTC interrupt wake source |
| wake_ext_i | input | 1 | External interrupt wake source |
| wake_nmi_i | input | 1 | NMI wake source |
| wake_dbg_i | input | 1 | Debugger forced-break wake source |
| pll_on_i | input | 1 | PLL currently enabled |
| src_sel_i | input | 1 | Requested clock source, 0 = oscillator, 1 = PLL |
| src_sel_o | output | 1 | Clock source applied, frozen across sleep |
| clk_en_o | output | 1 | System clock gate enable |
| osc_en_o | output | 1 | High-speed oscillator enable |
| cfg_err_o | output | 1 | Illegal oscillator-off sleep was attempted |

## Verification
The hardest case to reach is a sleep request that arrives while the stabilization timer is still counting. That request has to survive both the clock release and the delay while the timer's done flag clears back through the synchronizers. The bench creates this case by waking the block and, a few cycles into the wait, sending a sleep pulse together with an external wake pulse. It then checks two things: the release time is no shorter than the programmed interval, and the clock drops again on its own soon after release. Release times are checked against windows derived from the ratio of the two clock periods. One run uses the largest scale, so the bench also confirms that the long count is honoured.

// File: rtl/sleep_osc_pkg.sv
package sleep_osc_pkg;
  localparam logic [7:0] UNLOCK_KEY = 8'h96;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAIT  = 2'd2
  } slp_state_e;

  typedef struct packed {
    logic [7:0] stab_cnt;
    logic       osc_off;
    logic       slow_scale;
    logic       wake_en;
  } opt_t;
endpackage

// File: rtl/osc_sync2.sv
module osc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/osc_opt_regs.sv
module osc_opt_regs
  import sleep_osc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output opt_t        opt_o
);
  logic [7:0] key_q;
  opt_t       opt_q;
  logic       unlocked;
  logic       unused_wbits;

  assign unlocked     = (key_q == UNLOCK_KEY);
  assign unused_wbits = ^{wdata_i[7:4], wdata_i[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      opt_q <= '0;
    end else if (wr_i) begin
      if (addr_i) begin
        key_q <= wdata_i[7:0];
      end else if (unlocked) begin
        opt_q.stab_cnt   <= wdata_i[15:8];
        opt_q.osc_off    <= wdata_i[3];
        opt_q.slow_scale <= wdata_i[2];
        opt_q.wake_en    <= wdata_i[0];
      end
    end
  end

  // field positions are the software-visible layout
  always_comb begin
    if (addr_i) rdata_o = {8'h00, key_q};
    else        rdata_o = {opt_q.stab_cnt, 4'b0000, opt_q.osc_off,
                           opt_q.slow_scale, 1'b0, opt_q.wake_en};
  end

  assign opt_o = opt_q;

  p_locked_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && !unlocked) |=> $stable(rdata_o) || addr_i);
  p_relock_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && (wdata_i[7:0] != UNLOCK_KEY)) |=> !unlocked);
endmodule

// File: rtl/osc_stab_timer.sv
module osc_stab_timer #(
  parameter int FAST_LOG2 = 7,
  parameter int SLOW_LOG2 = 13
) (
  input  logic       osc_clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [7:0] cnt_i,
  input  logic       slow_i,
  output logic       done_o
);
  localparam int PRE_W = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;
  localparam logic [PRE_W-1:0] SLOW_LAST = PRE_W'((1 << SLOW_LOG2) - 1);
  localparam logic [PRE_W-1:0] FAST_LAST = PRE_W'((1 << FAST_LOG2) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [7:0]       tick_q;
  logic             done_q;
  logic [PRE_W-1:0] unit_last;
  logic [7:0]       target;

  // cnt_i and slow_i are quasi-static: software may not change them during sleep
  assign unit_last = slow_i ? SLOW_LAST : FAST_LAST;
  assign target    = (cnt_i == 8'd0) ? 8'd1 : cnt_i;

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= '0;
      done_q <= 1'b0;
    end else if (!run_i) begin
      pre_q  <= '0;
      tick_q <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (pre_q == unit_last) begin
        pre_q  <= '0;
        tick_q <= tick_q + 8'd1;
        if (tick_q + 8'd1 == target) done_q <= 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;

  p_done_only_running_r8: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> run_i);
  p_done_sticky_r8: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (done_o && run_i) |=> done_o);
endmodule

// File: rtl/osc_sleep_fsm.sv
module osc_sleep_fsm
  import sleep_osc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic wake_rtc_i,
  input  logic wake_ext_i,
  input  logic wake_nmi_i,
  input  logic wake_dbg_i,
  input  logic wake_en_i,
  input  logic osc_off_i,
  input  logic pll_on_i,
  input  logic src_sel_i,
  input  logic done_i,
  output logic run_o,
  output logic clk_en_o,
  output logic osc_en_o,
  output logic src_sel_o,
  output logic cfg_err_o
);
  slp_state_e state_q, state_d;
  logic pend_q, off_q, src_q, cfg_q;
  logic wake, enter, legal;

  assign wake  = wake_nmi_i | wake_dbg_i | (wake_en_i & (wake_rtc_i | wake_ext_i));
  assign legal = !pll_on_i && !src_sel_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if ((sleep_req_i || pend_q) && !done_i) state_d = ST_SLEEP;
      ST_SLEEP: if (wake) state_d = ST_WAIT;
      ST_WAIT:  if (done_i) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  assign enter = (state_q == ST_RUN) && (state_d == ST_SLEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      pend_q  <= 1'b0;
      off_q   <= 1'b0;
      src_q   <= 1'b0;
      cfg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (enter)                                  pend_q <= 1'b0;
      else if (sleep_req_i && state_q != ST_SLEEP) pend_q <= 1'b1;
      if (state_q == ST_RUN) src_q <= src_sel_i;
      if (enter) begin
        off_q <= osc_off_i && legal;
        cfg_q <= osc_off_i && !legal;
      end
    end
  end

  assign run_o     = (state_q == ST_WAIT);
  assign clk_en_o  = (state_q == ST_RUN);
  assign osc_en_o  = !((state_q == ST_SLEEP) && off_q);
  assign src_sel_o = (state_q == ST_RUN) ? src_sel_i : src_q;
  assign cfg_err_o = cfg_q;

  p_sleep_gates_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && sleep_req_i && !done_i) |=> !clk_en_o);
  p_release_osc_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> osc_en_o);
  p_src_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_o && !$past(clk_en_o)) |-> $stable(src_sel_o));
  p_cfg_osc_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !clk_en_o) |-> osc_en_o);
  p_wait_ignores_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !done_i) |=> (run_o && !clk_en_o));
endmodule

// File: rtl/sleep_osc_ctrl.sv
module sleep_osc_ctrl
  import sleep_osc_pkg::*;
#(
  parameter int FAST_LOG2 = 7,
  parameter int SLOW_LOG2 = 13
) (
  input  logic        clk_i,
  input  logic        osc_clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic        sleep_req_i,
  input  logic        wake_rtc_i,
  input  logic        wake_ext_i,
  input  logic        wake_nmi_i,
  input  logic        wake_dbg_i,
  input  logic        pll_on_i,
  input  logic        src_sel_i,
  output logic        src_sel_o,
  output logic        clk_en_o,
  output logic        osc_en_o,
  output logic        cfg_err_o
);
  opt_t opt;
  logic run_sys, run_osc, done_osc, done_sys;

  osc_opt_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .opt_o   (opt)
  );

  osc_sync2 #(.W(1)) u_run_sync (
    .clk_i  (osc_clk_i),
    .rst_ni (rst_ni),
    .d_i    (run_sys),
    .q_o    (run_osc)
  );

  osc_stab_timer #(
    .FAST_LOG2 (FAST_LOG2),
    .SLOW_LOG2 (SLOW_LOG2)
  ) u_timer (
    .osc_clk_i (osc_clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_osc),
    .cnt_i     (opt.stab_cnt),
    .slow_i    (opt.slow_scale),
    .done_o    (done_osc)
  );

  osc_sync2 #(.W(1)) u_done_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (done_osc),
    .q_o    (done_sys)
  );

  osc_sleep_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .wake_rtc_i  (wake_rtc_i),
    .wake_ext_i  (wake_ext_i),
    .wake_nmi_i  (wake_nmi_i),
    .wake_dbg_i  (wake_dbg_i),
    .wake_en_i   (opt.wake_en),
    .osc_off_i   (opt.osc_off),
    .pll_on_i    (pll_on_i),
    .src_sel_i   (src_sel_i),
    .done_i      (done_sys),
    .run_o       (run_sys),
    .clk_en_o    (clk_en_o),
    .osc_en_o    (osc_en_o),
    .src_sel_o   (src_sel_o),
    .cfg_err_o   (cfg_err_o)
  );
endmodule

// File: tb/sleep_osc_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_osc_ctrl_bench;
  logic clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic sleep_req = 1'b0, w_rtc = 1'b0, w_ext = 1'b0, w_nmi = 1'b0, w_dbg = 1'b0;
  logic pll_on = 1'b0, src_sel = 1'b0;
  logic src_sel_q, clk_en, osc_en, cfg_err;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;      // 50 MHz system clock
  always #25 osc_clk = ~osc_clk;  // 20 MHz oscillator

  sleep_osc_ctrl u_sleep_osc_ctrl (
    .clk_i(clk), .osc_clk_i(osc_clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .sleep_req_i(sleep_req),
    .wake_rtc_i(w_rtc), .wake_ext_i(w_ext), .wake_nmi_i(w_nmi), .wake_dbg_i(w_dbg),
    .pll_on_i(pll_on), .src_sel_i(src_sel), .src_sel_o(src_sel_q),
    .clk_en_o(clk_en), .osc_en_o(osc_en), .cfg_err_o(cfg_err)
  );

  // {addr, wdata, expected option readback, expected protect readback}
  localparam logic [40:0] VECS [8] = '{
    {1'b0, 16'hFFFF, 16'h0000, 8'h00},
    {1'b1, 16'h0096, 16'h0000, 8'h96},
    {1'b0, 16'hFFFF, 16'hFF0D, 8'h96},
    {1'b0, 16'h1204, 16'h1204, 8'h96},
    {1'b1, 16'h3311, 16'h1204, 8'h11},
    {1'b0, 16'hAAAA, 16'h1204, 8'h11},
    {1'b1, 16'h0096, 16'h1204, 8'h96},
    {1'b0, 16'h0001, 16'h0001, 8'h96}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int n, input int lo, input int hi);
    tests++;
    if (n < lo || n > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, n, lo, hi);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic go_sleep();
    repeat (20) @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  // which: 0 rtc, 1 ext, 2 nmi, 3 dbg
  task automatic wake(input int which);
    @(negedge clk);
    w_rtc = (which == 0); w_ext = (which == 1); w_nmi = (which == 2); w_dbg = (which == 3);
    @(negedge clk);
    w_rtc = 0; w_ext = 0; w_nmi = 0; w_dbg = 0;
  endtask

  task automatic wait_release(output int n);
    n = 1;
    while (clk_en !== 1'b1 && n < 40000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(1'b0, d); check("R3 reset option", d, 16'h0000);
    rd(1'b1, d); check("R1 reset protect", d, 16'h0000);
    check("R4 reset clk_en", clk_en, 1);
    check("R5 reset osc_en", osc_en, 1);
    check("R6 reset cfg_err", cfg_err, 0);

    foreach (VECS[i]) begin
      wr(VECS[i][40], VECS[i][39:24]);
      rd(1'b0, d); check($sformatf("R1/R2/R3 vec%0d option", i), d, VECS[i][23:8]);
      rd(1'b1, d); check($sformatf("R1 vec%0d protect", i), d, {8'h00, VECS[i][7:0]});
    end

    // osc-off sleep, NMI wake, count 2 scale fast: 256 osc cycles = 640 sys
    wr(1'b0, 16'h0209);
    go_sleep();
    check("R4 clk gated", clk_en, 0);
    check("R5 osc off", osc_en, 0);
    repeat (20) @(negedge clk);
    check("R5 osc off held", osc_en, 0);
    wake(2);
    check("R8 osc on at wake", osc_en, 1);
    check("R8 clk still gated", clk_en, 0);
    wait_release(n);
    check_rng("R8 wait 2x128", n, 640, 660);

    // wake during wait ignored, sleep during wait held
    go_sleep();
    wake(3);
    repeat (5) @(negedge clk);
    sleep_req = 1'b1; w_ext = 1'b1;
    @(negedge clk); sleep_req = 1'b0; w_ext = 1'b0;
    check("R10 still waiting", clk_en, 0);
    wait_release(n);
    check_rng("R10 wait not shortened", n, 634, 660);
    n = 0;
    while (clk_en === 1'b1 && n < 60) begin @(negedge clk); n++; end
    check("R10 held sleep taken", clk_en, 0);
    check("R10 held sleep osc off", osc_en, 0);
    wake(2);
    wait_release(n);

    // wake enable cleared: rtc/ext masked, debug wakes
    wr(1'b0, 16'h0208);
    go_sleep();
    wake(0);
    repeat (10) @(negedge clk);
    check("R7 rtc masked", osc_en, 0);
    wake(1);
    repeat (10) @(negedge clk);
    check("R7 ext masked", {clk_en, osc_en}, 2'b00);
    wake(3);
    check("R7 dbg wakes", osc_en, 1);
    wait_release(n);
    check_rng("R7 dbg release", n, 640, 660);

    // wake enable set: rtc wakes
    wr(1'b0, 16'h0209);
    go_sleep();
    wake(0);
    check("R7 rtc wakes", osc_en, 1);
    wait_release(n);

    // illegal osc-off with PLL on
    pll_on = 1'b1;
    go_sleep();
    check("R6 cfg_err set", cfg_err, 1);
    check("R6 osc kept on", osc_en, 1);
    wake(2);
    wait_release(n);
    pll_on = 1'b0;
    go_sleep();
    check("R6 cfg_err cleared", cfg_err, 0);
    check("R6 legal osc off", osc_en, 0);
    wake(2);
    wait_release(n);

    // source frozen across sleep, osc-off disabled
    wr(1'b0, 16'h0201);
    src_sel = 1'b1;
    go_sleep();
    check("R9 src captured", src_sel_q, 1);
    check("R5 osc stays on", osc_en, 1);
    check("R6 pll src no error when osc kept", cfg_err, 0);
    src_sel = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 src frozen", src_sel_q, 1);
    wake(2);
    repeat (5) @(negedge clk);
    check("R9 src frozen in wait", src_sel_q, 1);
    wait_release(n);
    @(negedge clk);
    check("R9 src follows after release", src_sel_q, 0);

    // count 0 = one unit (128 osc = 320 sys)
    wr(1'b0, 16'h0009);
    go_sleep();
    wake(2);
    wait_release(n);
    check_rng("R8 count zero one unit", n, 320, 340);

    // slow scale: 1 x 8192 osc = 20480 sys
    wr(1'b0, 16'h010D);
    go_sleep();
    wake(2);
    wait_release(n);
    check_rng("R8 slow scale", n, 20480, 20500);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule